// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the auto-address-increment word programming mode of a serial flash controller. It sits behind the command decoder. It receives opcodes that are already decoded, together with an address field and a two-byte data field. It keeps its own word pointer and issues one two-byte program request to the array for each accepted word. Only the command that enters the mode carries an address. Every later word command carries data only, and that data goes to the next pair of sequential addresses.

The block reads the write-enable latch and the protection boundary from the status register. When the mode ends, it pulses a clear back to the write-enable latch. It drives the AAI status flag while the mode is active. As an option, it can show ready/busy on the serial output while chip select is low. The block has three states. `ST_IDLE` means the mode is off. `ST_BUSY` means a word program is in progress. `ST_READY` means the mode is active and waiting for the next word.

The state transitions are:
- **enter**: `ST_IDLE` to `ST_BUSY`.
- **word_done**: `ST_BUSY` to `ST_READY`.
- **range_exit**: `ST_BUSY` to `ST_IDLE`.
- **next_word**: `ST_READY` to `ST_BUSY`.
- **wrdi_exit**: `ST_READY` to `ST_IDLE`.

Top module: `aai_word_seq`

## Requirements
- R1: In `ST_IDLE`, opcode ADh with `wel_i`=1 and an unprotected word starts the mode. One clock edge later, `prog_req` pulses for one cycle. `prog_addr` is `cmd_addr` with bit 0 cleared. `prog_data[15:8]` (the first byte) goes to that even address and `prog_data[7:0]` goes to the odd address above it. `aai_flag` becomes 1.
- R2: Entry is refused, and the state stays unchanged, if `wel_i`=0 or if the even base plus 1 is not below `prot_floor`. Every address at or above `prot_floor` is protected.
- R3: In `ST_READY`, opcode ADh programs the word at the previous word address plus 2. `cmd_addr` is ignored.
- R4: After each request, `busy` stays high for exactly `PROG_CYCLES` cycles. An ADh that arrives while `busy` is high is ignored.
- R5: While the mode is active, only ADh, 05h (status read, no effect here) and 04h are acted on. All other opcodes (for example 06h, 02h and 70h) change nothing.
- R6: Opcode 04h in `ST_READY` ends the mode. `aai_flag` drops to 0 and `wel_clr` pulses for one cycle.
- R7: The pointer never wraps. When a word completes and the next word would reach `prot_floor` or the top of the address space, the mode exits, `aai_flag` drops to 0 and `wel_clr` pulses.
- R8: Opcode 70h, accepted only in `ST_IDLE`, enables the hardware indicator. While the mode is active and `cs_n`=0, `so_oe`=1 and `so_level` is 0 when busy and 1 when ready. When `cs_n`=1, `so_oe`=0 in the same cycle.
- R9: Opcode 80h, accepted only in `ST_IDLE`, disables the indicator. After that, `so_oe` stays 0 during the mode.
- R10: After reset, `aai_flag`, `busy`, `prog_req` and `wel_clr` are 0 and the indicator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_code | input | 8 | Opcode |
| cmd_addr | input | AW | Address field, used only on entry |
| cmd_data | input | 2*DW | Two data bytes, first byte in the upper half |
| wel_i | input | 1 | Write-enable latch state |
| prot_floor | input | AW+1 | Lowest protected address; 2^AW means nothing is protected |
| cs_n | input | 1 | Chip select, active low |
| prog_req | output | 1 | One-cycle word program request |
| prog_addr | output | AW | Even address of the word |
| prog_data | output | 2*DW | Word data |
| busy | output | 1 | Word program in progress |
| aai_flag | output | 1 | AAI status bit |
| wel_clr | output | 1 | One-cycle clear of the write-enable latch |
| so_oe | output | 1 | Serial output drive enable for the indicator |
| so_level | output | 1 | Indicator level: 1 ready, 0 busy |

## Verification
Assertions check the following on every cycle:
- Requests occur only inside the mode, last exactly one cycle and target even addresses.
- The pointer always steps by exactly two.
- The mode can be entered only when write enable was present.
- `wel_clr` coincides with leaving the mode.
- The indicator never drives while chip select is high.

Only the bench scenarios can show the rest:
- Ignored opcodes and ignored addresses leave the pointer untouched.
- The busy window has the exact length.
- The boundary exit happens at the protection floor and at the top of the address space.
- The 70h/80h setting persists from idle into a later mode.

// File: rtl/aai_pkg.sv
package aai_pkg;
    localparam logic [7:0] OP_WORD   = 8'hAD;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_DISABLE = 8'h04;
    localparam logic [7:0] OP_IND_ON  = 8'h70;
    localparam logic [7:0] OP_IND_OFF = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2
    } aai_state_t;
endpackage

// File: rtl/aai_busy_timer.sv
module aai_busy_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
endmodule

// File: rtl/aai_addr_ptr.sv
module aai_addr_ptr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] load_addr,
    input  logic [AW:0]   floor,
    output logic [AW-1:0] base_addr,
    output logic [AW-1:0] cur_addr,
    output logic          word_ok,
    output logic          at_end
);
    localparam logic [AW:0] ONE = (AW+1)'(1);
    localparam logic [AW:0] TWO = (AW+1)'(2);

    logic [AW:0] base_w;
    logic [AW:0] ptr;

    assign base_w    = {1'b0, load_addr} & ~ONE;
    assign base_addr = base_w[AW-1:0];
    assign word_ok   = (base_w + ONE) < floor;
    assign cur_addr  = ptr[AW-1:0];
    assign at_end    = (ptr + ONE) >= floor;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= base_w + TWO;
        else if (adv)
            ptr <= ptr + TWO;
    end

    p_ptr_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[0] == 1'b0);
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> ptr == $past(ptr) + TWO);
endmodule

// File: rtl/aai_so_ind.sv
module aai_so_ind (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic mode_on,
    input  logic busy,
    input  logic cs_n,
    output logic so_oe,
    output logic so_level
);
    logic ind_en;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ind_en <= 1'b0;
        else if (set_en)
            ind_en <= 1'b1;
        else if (clr_en)
            ind_en <= 1'b0;
    end

    assign so_oe    = ind_en && mode_on && !cs_n;
    assign so_level = !busy;

    p_so_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);
    p_so_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |-> !so_oe);
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
    import aai_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 8,
    parameter int PROG_CYCLES = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [2*DW-1:0] cmd_data,
    input  logic            wel_i,
    input  logic [AW:0]     prot_floor,
    input  logic            cs_n,
    output logic            prog_req,
    output logic [AW-1:0]   prog_addr,
    output logic [2*DW-1:0] prog_data,
    output logic            busy,
    output logic            aai_flag,
    output logic            wel_clr,
    output logic            so_oe,
    output logic            so_level
);
    localparam int WW = 2 * DW;

    aai_state_t state_q, state_d;

    logic            t_done;
    logic            word_ok, at_end;
    logic [AW-1:0]   base_addr, cur_addr;
    logic            go_enter, go_next, go_exit;
    logic            ind_set, ind_clr;
    logic            req_q, clr_q;
    logic [AW-1:0]   addr_q;
    logic [WW-1:0]   data_q;

    // next-state and transition decode
    always_comb begin
        state_d  = state_q;
        go_enter = 1'b0;
        go_next  = 1'b0;
        go_exit  = 1'b0;
        ind_set  = 1'b0;
        ind_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && cmd_code == OP_WORD && wel_i && word_ok) begin
                    go_enter = 1'b1;
                    state_d  = ST_BUSY;
                end
                ind_set = cmd_valid && cmd_code == OP_IND_ON;
                ind_clr = cmd_valid && cmd_code == OP_IND_OFF;
            end
            ST_BUSY: begin
                if (t_done) begin
                    if (at_end) begin
                        go_exit = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_READY;
                    end
                end
            end
            ST_READY: begin
                if (cmd_valid && cmd_code == OP_WORD) begin
                    go_next = 1'b1;
                    state_d = ST_BUSY;
                end else if (cmd_valid && cmd_code == OP_DISABLE) begin
                    go_exit = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            clr_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            req_q <= go_enter || go_next;
            clr_q <= go_exit;
            if (go_enter) begin
                addr_q <= base_addr;
                data_q <= cmd_data;
            end else if (go_next) begin
                addr_q <= cur_addr;
                data_q <= cmd_data;
            end
        end
    end

    assign prog_req  = req_q;
    assign prog_addr = addr_q;
    assign prog_data = data_q;
    assign wel_clr   = clr_q;
    assign busy      = (state_q == ST_BUSY);
    assign aai_flag  = (state_q != ST_IDLE);

    aai_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_enter || go_next),
        .done  (t_done)
    );

    aai_addr_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_enter),
        .adv       (go_next),
        .load_addr (cmd_addr),
        .floor     (prot_floor),
        .base_addr (base_addr),
        .cur_addr  (cur_addr),
        .word_ok   (word_ok),
        .at_end    (at_end)
    );

    aai_so_ind u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ind_set),
        .clr_en   (ind_clr),
        .mode_on  (aai_flag),
        .busy     (busy),
        .cs_n     (cs_n),
        .so_oe    (so_oe),
        .so_level (so_level)
    );

    p_req_in_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (aai_flag && busy));
    p_req_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);
    p_req_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !prog_addr[0]);
    p_enter_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aai_flag) |-> $past(wel_i));
    p_clr_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> (!aai_flag && $past(aai_flag)));
endmodule

// File: tb/sim_aai_word_seq.sv
`timescale 1ns/1ps
module sim_aai_word_seq;
    localparam int AW = 20;
    localparam int P  = 6;
    localparam logic [AW:0] FULL = 21'h100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [AW-1:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic wel_i = 1'b1;
    logic [AW:0] prot_floor = FULL;
    logic cs_n = 1'b1;
    logic prog_req, busy, aai_flag, wel_clr, so_oe, so_level;
    logic [AW-1:0] prog_addr;
    logic [15:0] prog_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    aai_word_seq #(.AW(AW), .DW(8), .PROG_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wel_i(wel_i),
        .prot_floor(prot_floor), .cs_n(cs_n), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy),
        .aai_flag(aai_flag), .wel_clr(wel_clr), .so_oe(so_oe), .so_level(so_level)
    );

    // {wel, addr, floor, expect_accept}
    localparam logic [42:0] VEC [6] = '{
        {1'b1, 20'h00123, 21'h100000, 1'b1},
        {1'b0, 20'h00010, 21'h100000, 1'b0},
        {1'b1, 20'h000FF, 21'h000100, 1'b1},
        {1'b1, 20'h00100, 21'h000100, 1'b0},
        {1'b1, 20'h00000, 21'h000000, 1'b0},
        {1'b1, 20'h80001, 21'h100000, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cs_n = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!aai_flag && !busy && !prog_req && !wel_clr && !so_oe, "R10 reset",
            {aai_flag, busy, prog_req, wel_clr, so_oe}, 0);
        cs_n = 1'b1;

        // table of entry attempts: R1, R2
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] a;
            logic exp_acc;
            wel_i = VEC[i][42];
            a = VEC[i][41:22];
            prot_floor = VEC[i][21:1];
            exp_acc = VEC[i][0];
            send(8'hAD, a, 16'hA500 ^ 16'(i));
            if (exp_acc) begin
                chk(prog_req && prog_addr == {a[AW-1:1], 1'b0} && prog_data == (16'hA500 ^ 16'(i))
                    && aai_flag, "R1 entry", {12'h0, prog_addr}, {12'h0, a[AW-1:1], 1'b0});
                wait_ready();
                if (aai_flag) send(8'h04, '0, '0);
            end else begin
                chk(!prog_req && !aai_flag, "R2 refuse", {prog_req, aai_flag}, 0);
            end
            @(negedge clk);
        end
        wel_i = 1'b1;
        prot_floor = FULL;

        // R4, R5, R3, R6
        send(8'hAD, 20'h00400, 16'h1122);
        chk(prog_req && prog_addr == 20'h00400, "R1 entry even", {12'h0, prog_addr}, 32'h400);
        send(8'hAD, 20'h12345, 16'h3344);
        chk(!prog_req && busy, "R4 word while busy ignored", {prog_req, busy}, 1);
        wait_ready();
        chk(aai_flag && !busy, "R4 ready", {aai_flag, busy}, 2);
        send(8'h06, '0, '0);
        send(8'h02, 20'h00800, 16'h0);
        send(8'h70, '0, '0);
        send(8'h05, '0, '0);
        chk(!prog_req && aai_flag && !busy, "R5 other opcodes ignored", {prog_req, aai_flag, busy}, 2);
        send(8'hAD, 20'hABCDE, 16'h5566);
        chk(prog_req && prog_addr == 20'h00402 && prog_data == 16'h5566, "R3 next word",
            {12'h0, prog_addr}, 32'h402);
        begin
            int n = 0;
            while (busy) begin n++; @(negedge clk); end
            chk(n == P, "R4 busy length", n, P);
        end
        send(8'h04, '0, '0);
        chk(wel_clr && !aai_flag, "R6 disable exits", {wel_clr, aai_flag}, 2);
        @(negedge clk);
        chk(!wel_clr, "R6 clear is a pulse", wel_clr, 0);
        // 70h during mode was ignored: indicator still off
        cs_n = 1'b0;
        send(8'hAD, 20'h00500, 16'h0);
        chk(!so_oe, "R5 70h in mode ignored", so_oe, 0);
        wait_ready();
        send(8'h04, '0, '0);
        cs_n = 1'b1;

        // R7 protection boundary exit
        prot_floor = 21'h000100;
        send(8'hAD, 20'h000FB, 16'h0101);
        chk(prog_req && prog_addr == 20'h000FA, "R7 entry near floor", {12'h0, prog_addr}, 32'hFA);
        wait_ready();
        chk(aai_flag, "R7 still in mode", aai_flag, 1);
        send(8'hAD, '0, 16'h0202);
        chk(prog_addr == 20'h000FC, "R7 second word", {12'h0, prog_addr}, 32'hFC);
        wait_ready();
        send(8'hAD, '0, 16'h0303);
        chk(prog_addr == 20'h000FE, "R7 last word", {12'h0, prog_addr}, 32'hFE);
        wait_ready();
        chk(wel_clr && !aai_flag, "R7 floor exit", {wel_clr, aai_flag}, 2);
        send(8'hAD, 20'h00100, 16'h0404);
        chk(!prog_req && !aai_flag, "R7 no further word", {prog_req, aai_flag}, 0);

        // R7 no wrap at top of space
        prot_floor = FULL;
        send(8'hAD, 20'hFFFFF, 16'h0505);
        chk(prog_req && prog_addr == 20'hFFFFE, "R7 top entry", {12'h0, prog_addr}, 32'hFFFFE);
        wait_ready();
        chk(wel_clr && !aai_flag, "R7 top exit no wrap", {wel_clr, aai_flag}, 2);

        // R8 indicator
        send(8'h70, '0, '0);
        cs_n = 1'b0;
        send(8'hAD, 20'h00200, 16'h0606);
        chk(so_oe && !so_level, "R8 busy level", {so_oe, so_level}, 2);
        wait_ready();
        chk(so_oe && so_level, "R8 ready level", {so_oe, so_level}, 3);
        cs_n = 1'b1;
        #1;
        chk(!so_oe, "R8 cs high releases", so_oe, 0);
        send(8'h04, '0, '0);

        // R9 indicator off
        send(8'h80, '0, '0);
        cs_n = 1'b0;
        send(8'hAD, 20'h00300, 16'h0707);
        chk(!so_oe && aai_flag, "R9 indicator disabled", {so_oe, aai_flag}, 1);
        wait_ready();
        send(8'h04, '0, '0);
        cs_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule